// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Reader

This block gives software a small register window onto a one-time-programmable fuse array of 128 words of 32 bits. Software picks a word address in the control register, optionally adjusts the strobe and relax counts in the timing register, and then writes the read command. The controller raises a busy flag and holds it through a strobe phase and a relax phase. It then captures the selected fuse word into a read-result register and drops busy.

The fuse array is a model with fixed contents. Words at or above a parameterised boundary count as inaccessible. Reading one of them ends the read with a sticky error flag set and a fixed sentinel word in the result register. The error flag is also set when software tries to disturb a read that is in progress. Software clears it through the clear alias of the control register.

The bus is a plain single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational on `reg_addr`. No back-pressure exists, because every access completes in one cycle.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0, the read-result register (0x40) reads 0, and the timing register (0x10) reads the default strobe-read, relax and strobe-program counts. Strobe-read sits in bits 21:16, relax in bits 15:12 and strobe-program in bits 11:0.
- R2: A write to offset 0x00 while idle loads the word address from bits 6:0 and the shadow-reload request from bit 10. Bits 31:16 read back 0x3E77 only if the last control write carried exactly that key in bits 31:16, and read 0 otherwise.
- R3: Writing a 1 to a bit at offset 0x04 sets that control bit, and writing a 1 at offset 0x08 clears it. The busy flag in bit 8 is unaffected by either alias.
- R4: Writing exactly 0x1 to offset 0x30 while idle starts a read and sets busy in bit 8. Writing any other value there starts nothing.
- R5: Busy stays high for strobe_read + relax + 2 cycles after the command edge. The read-result register is updated on the edge where busy falls.
- R6: A read of word a below the valid boundary returns {b, ~b, 8'h5A, b ^ 8'h3C}, where b = {1'b0, a}.
- R7: A read of a word at or above the valid boundary sets ERR (bit 9) and returns 0xBADABADA.
- R8: While busy, writes of 0x1 to the command register, writes to the timing register, control writes, and alias writes touching bits 6:0 leave the address and timing unchanged and set ERR.
- R9: ERR is sticky across later successful reads and is cleared by writing bit 9 at offset 0x08.
- R10: The read-result register holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
The bench builds the block with a default strobe-read count of 3, a relax count of 2 and a valid boundary of 120 words. These defaults make the busy window seven cycles, so it can be counted exactly. The boundary places the error words at the top of the 7-bit address range, where they can be reached. The bench also rewrites the timing register to zero counts and to other mixed counts, which exercises the shortest window and windows of other lengths.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int ADDR_W = 7;
  localparam int WORDS  = 1 << ADDR_W;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_SET  = 8'h04;
  localparam logic [7:0] OFF_CLR  = 8'h08;
  localparam logic [7:0] OFF_TIM  = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h20;
  localparam logic [7:0] OFF_CMD  = 8'h30;
  localparam logic [7:0] OFF_RES  = 8'h40;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] SENTINEL   = 32'hBADABADA;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STROBE, SQ_RELAX} seq_state_e;

  function automatic logic [31:0] fuse_word(input logic [ADDR_W-1:0] a);
    logic [7:0] b;
    b = {1'b0, a};
    return {b, ~b, 8'h5A, b ^ 8'h3C};
  endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_rd_pkg::*;
#(
  parameter int VALID_WORDS = 120
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [31:0]       word,
  output logic              bad
);
  logic [31:0] mem [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign mem[i] = fuse_word(ADDR_W'(i));
  end

  assign word = mem[addr];
  assign bad  = ({1'b0, addr} >= (ADDR_W+1)'(VALID_WORDS));
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_rd_pkg::*;
#(
  parameter int SR_W = 6,
  parameter int RX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SR_W-1:0] sread,
  input  logic [RX_W-1:0] relax,
  output logic            busy,
  output logic            done
);
  localparam int CW = (SR_W > RX_W) ? SR_W : RX_W;

  seq_state_e st_q;
  logic [CW-1:0] cnt_q;

  assign busy = (st_q != SQ_IDLE);
  assign done = (st_q == SQ_RELAX) && (cnt_q == CW'(relax));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          st_q  <= SQ_STROBE;
          cnt_q <= '0;
        end
        SQ_STROBE: if (cnt_q == CW'(sread)) begin
          st_q  <= SQ_RELAX;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        SQ_RELAX: if (done) begin
          st_q  <= SQ_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  p_done_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_done_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int          VALID_WORDS = 120,
  parameter int          SR_W        = 6,
  parameter int          RX_W        = 4,
  parameter int          SP_W        = 12,
  parameter logic [5:0]  DEF_SREAD   = 6'd3,
  parameter logic [3:0]  DEF_RELAX   = 4'd2,
  parameter logic [11:0] DEF_SPROG   = 12'd100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       key_q;
  logic              reload_q, err_q;
  logic [SR_W-1:0]   sread_q;
  logic [RX_W-1:0]   relax_q;
  logic [SP_W-1:0]   sprog_q;
  logic [31:0]       data_q, rdata_q;

  logic seq_busy, seq_done, seq_start, arr_bad;
  logic [31:0] arr_word;

  wire wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
  wire wr_set  = reg_wr && (reg_addr == OFF_SET);
  wire wr_clr  = reg_wr && (reg_addr == OFF_CLR);
  wire wr_tim  = reg_wr && (reg_addr == OFF_TIM);
  wire wr_data = reg_wr && (reg_addr == OFF_DATA);
  wire wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
  wire cmd_go  = wr_cmd && (reg_wdata == 32'h1);
  wire w_addr  = |reg_wdata[ADDR_W-1:0];

  wire violate = seq_busy && (wr_ctrl || wr_tim || cmd_go ||
                              ((wr_set || wr_clr) && w_addr));
  assign seq_start = cmd_go && !seq_busy;

  fuse_seq #(.SR_W(SR_W), .RX_W(RX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .sread(sread_q), .relax(relax_q), .busy(seq_busy), .done(seq_done)
  );

  fuse_array #(.VALID_WORDS(VALID_WORDS)) arr_i (
    .addr(addr_q), .word(arr_word), .bad(arr_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      key_q    <= '0;
      reload_q <= 1'b0;
      err_q    <= 1'b0;
      sread_q  <= DEF_SREAD;
      relax_q  <= DEF_RELAX;
      sprog_q  <= DEF_SPROG;
      data_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (!seq_busy) begin
        if (wr_ctrl)     addr_q <= reg_wdata[ADDR_W-1:0];
        else if (wr_set) addr_q <= addr_q | reg_wdata[ADDR_W-1:0];
        else if (wr_clr) addr_q <= addr_q & ~reg_wdata[ADDR_W-1:0];
        if (wr_tim) begin
          sprog_q <= reg_wdata[SP_W-1:0];
          relax_q <= reg_wdata[12 +: RX_W];
          sread_q <= reg_wdata[16 +: SR_W];
        end
      end
      if (wr_ctrl) key_q <= (reg_wdata[31:16] == UNLOCK_KEY) ? UNLOCK_KEY : 16'h0;

      if (wr_ctrl)     reload_q <= reg_wdata[10];
      else if (wr_set) reload_q <= reload_q | reg_wdata[10];
      else if (wr_clr) reload_q <= reload_q & ~reg_wdata[10];

      if (violate || (seq_done && arr_bad)) err_q <= 1'b1;
      else if (wr_ctrl) err_q <= reg_wdata[9];
      else if (wr_set)  err_q <= err_q | reg_wdata[9];
      else if (wr_clr)  err_q <= err_q & ~reg_wdata[9];

      if (wr_data) data_q <= reg_wdata;
      if (seq_done) rdata_q <= arr_bad ? SENTINEL : arr_word;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFF_CTRL, OFF_SET, OFF_CLR:
        reg_rdata = {key_q, 5'b0, reload_q, err_q, seq_busy, 1'b0, addr_q};
      OFF_TIM:  reg_rdata = {10'b0, sread_q, relax_q, sprog_q};
      OFF_DATA: reg_rdata = data_q;
      OFF_RES:  reg_rdata = rdata_q;
      default:  reg_rdata = '0;
    endcase
  end

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(addr_q));
  p_timing_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> ($stable(sread_q) && $stable(relax_q)));
  p_sentinel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && arr_bad) |=> (rdata_q == SENTINEL && err_q));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(rdata_q));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !wr_clr && !wr_ctrl) |=> err_q);
endmodule

// File: tb/fuse_rd_ctrl_tb.sv
module fuse_rd_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] SENT = 32'hBADABADA;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  fuse_rd_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] exp_word(input logic [6:0] a);
    logic [7:0] b;
    b = {1'b0, a};
    return {b, ~b, 8'h5A, b ^ 8'h3C};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // issues a command and counts busy-high samples until it drops
  task automatic run_read(output int n);
    logic [31:0] v;
    wr(8'h30, 32'h1);
    n = 0;
    rd(8'h00, v);
    while (v[8] && n < 200) begin
      n++;
      @(negedge clk);
      rd(8'h00, v);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h40, v); chk("R1 result", v, 32'h0);
    rd(8'h10, v); chk("R1 timing", v, 32'h0003_2064);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(8'h00, 32'h3E77_0405); rd(8'h00, v); chk("R2 key ok", v, 32'h3E77_0405);
    wr(8'h00, 32'h3E76_0011); rd(8'h00, v); chk("R2 bad key", v, 32'h0000_0011);
    wr(8'h04, 32'h0000_0622); rd(8'h00, v); chk("R3 set", v, 32'h0000_0633);
    wr(8'h08, 32'h0000_0611); rd(8'h00, v); chk("R3 clr", v, 32'h0000_0022);
    wr(8'h04, 32'h0000_0100); rd(8'h00, v); chk("R3 busy not set", v, 32'h0000_0022);
  endtask

  task automatic t_read_basic;
    logic [31:0] v; int n;
    wr(8'h00, 32'h0000_0005);
    wr(8'h30, 32'h2); rd(8'h00, v); chk("R4 other value no start", {31'b0, v[8]}, 32'h0);
    run_read(n); chk("R5 default window", n, 32'd7);
    rd(8'h40, v); chk("R6 word 5", v, exp_word(7'd5));
    wr(8'h10, 32'h0000_0000); wr(8'h00, 32'h0000_0077);
    run_read(n); chk("R5 min window", n, 32'd2);
    rd(8'h40, v); chk("R6 word 0x77", v, exp_word(7'h77));
    wr(8'h10, 32'h0005_1000); wr(8'h00, 32'h0000_0000);
    run_read(n); chk("R5 mixed window", n, 32'd8);
    rd(8'h40, v); chk("R6 word 0", v, exp_word(7'h0));
    rd(8'h00, v); chk("R4 no err", {31'b0, v[9]}, 32'h0);
  endtask

  task automatic t_bad;
    logic [31:0] v; int n;
    wr(8'h00, 32'h0000_0078);
    run_read(n);
    rd(8'h40, v); chk("R7 sentinel", v, SENT);
    rd(8'h00, v); chk("R7 err", {31'b0, v[9]}, 32'h1);
    wr(8'h00, 32'h0000_0203);
    run_read(n);
    rd(8'h40, v); chk("R9 good read", v, exp_word(7'd3));
    rd(8'h00, v); chk("R9 sticky", {31'b0, v[9]}, 32'h1);
    wr(8'h08, 32'h0000_0200); rd(8'h00, v); chk("R9 cleared", {31'b0, v[9]}, 32'h0);
  endtask

  task automatic t_busy_block;
    logic [31:0] v;
    wr(8'h10, 32'h0003_2064);
    wr(8'h00, 32'h0000_0009);
    wr(8'h30, 32'h1);
    wr(8'h00, 32'h0000_0011);
    rd(8'h00, v); chk("R8 addr held", {25'b0, v[6:0]}, 32'h9);
    chk("R8 err set", {31'b0, v[9]}, 32'h1);
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, v); chk("R8 timing held", v, 32'h0003_2064);
    repeat (10) @(negedge clk);
    rd(8'h40, v); chk("R8 read completes", v, exp_word(7'd9));
    wr(8'h08, 32'h0000_0200);
    wr(8'h20, 32'h1234_5678);
    repeat (5) @(negedge clk);
    rd(8'h40, v); chk("R10 result held", v, exp_word(7'd9));
    rd(8'h20, v); chk("R10 data reg", v, 32'h1234_5678);
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_read_basic();
    t_bad();
    t_busy_block();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule